// File: doc/BRIEF.md
# Three-Channel DMA Request Arbiter

This block sits in front of a three-channel DMA engine. Each channel has a request line that is brought through a two-stage synchronizer and then captured into a pending flag. A fixed-priority arbiter chooses the next channel to serve. The grant is registered and one-hot, and each grant is announced with a start strobe. A stub sequencer models how long the transfer occupies the engine: it has a programmable number of clock cycles per block and a programmable number of blocks. A one-cycle done pulse marks the end of a transfer.

Four transfer modes are available. Burst keeps the grant until the block count runs out. Step gives the grant back after every block and has to win arbitration again for the next one. Block serves one block for each request. Continuous keeps going while the synchronized request stays high, and stops at a block boundary or when the count runs out.

A captured request stays pending until its transfer ends. A channel that asks again while its own transfer is running is ignored. Between two transfers there is always at least one arbitration cycle, so a higher-priority channel can take the engine before the same channel restarts.

Top module: `dmarq_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `grant`, `busy`, `xfer_start` and `xfer_done` are all zero.
- R2: `req_in` passes two flip-flops before capture. With the engine idle, a channel's grant goes high after the fourth rising edge that samples its request high. This is always at least three cycles after the request.
- R3: A request that is high for only one sampling edge is still captured, and it is served once.
- R4: The grant is one-hot or zero. When several channels are pending, channel 0 wins over channel 1, and channel 1 wins over channel 2.
- R5: A request that is high only while the same channel's transfer is in progress creates no further transfer.
- R6: After a grant falls, at least one cycle passes with `grant` all zero before the next grant. If another channel was already pending, the gap is exactly one cycle and the winner is the highest-priority pending channel.
- R7: Suppose a channel's request is still high when its transfer ends and no other channel is pending. That channel is granted again after exactly two all-zero grant cycles.
- R8: Burst mode (`cfg_mode`=0) holds the grant for `cfg_blocks` × `cfg_blk_cycles` consecutive cycles. A value of 0 in either field counts as 1. `xfer_done` is high in the first cycle after the grant falls.
- R9: Step mode (`cfg_mode`=1) releases the grant after every block and arbitrates again. The channel is served `cfg_blocks` blocks in total, and other channels may be served in between.
- R10: Block mode (`cfg_mode`=2) serves exactly one block of `cfg_blk_cycles` cycles per request, whatever `cfg_blocks` holds.
- R11: Continuous mode (`cfg_mode`=3) keeps going while the synchronized request is high at a block boundary. It ends at the first boundary where that request is low, or when the count runs out.
- R12: While `ch_en[c]` is low, channel c captures no request, and any request it had pending is cleared. A grant already running is not cut short.
- R13: `busy[c]` is high from channel c's grant until its transfer ends, including the gaps between step-mode blocks. `xfer_start` pulses once in the first cycle of every grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_in | input | NUM_CH | Per-channel request lines, asynchronous |
| ch_en | input | NUM_CH | Per-channel enable |
| cfg_mode | input | 2 | Mode: 0 burst, 1 step, 2 block, 3 continuous |
| cfg_blocks | input | BLK_W | Number of blocks per transfer (0 counts as 1) |
| cfg_blk_cycles | input | CYC_W | Cycles per block (0 counts as 1) |
| grant | output | NUM_CH | Registered one-hot grant |
| busy | output | NUM_CH | Per-channel transfer-open flag |
| xfer_start | output | 1 | One-cycle strobe in the first cycle of a grant |
| xfer_done | output | 1 | One-cycle pulse after a transfer ends |

## Verification
Some properties are checked on every cycle. The grant must be one-hot or zero. Every new grant must follow an all-zero grant cycle. The start strobe must line up exactly with grant rises, and the done pulse must fall only on idle cycles. A granted channel must be busy, a grant may only come from a captured request, and a disabled channel must hold no pending flag. Other behaviours can only be shown by the bench scenarios. These are the exact four-cycle start latency, the ignore window for re-requests, the one- and two-cycle arbitration gaps, preemption by a higher-priority channel, the interleaving of step mode, and the length of the grant in each mode.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;
  typedef enum logic [1:0] {
    XM_BURST = 2'd0,
    XM_STEP  = 2'd1,
    XM_BLOCK = 2'd2,
    XM_CONT  = 2'd3
  } xfer_mode_e;
endpackage

// File: rtl/dmarq_sync.sv
module dmarq_sync #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] async_in,
  output logic [NUM_CH-1:0] sync_out
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_in[c];
        stab_q <= meta_q;
      end
    end
    assign sync_out[c] = stab_q;
  end
endmodule

// File: rtl/dmarq_pend.sv
module dmarq_pend #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_s,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] busy,
  input  logic [NUM_CH-1:0] clr,
  output logic [NUM_CH-1:0] pend
);
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] pend_d;

  always_comb begin
    pend_d = (pend_q | (req_s & ~busy)) & ch_en & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/dmarq_prio.sv
module dmarq_prio #(
  parameter int NUM_CH = 3
) (
  input  logic [NUM_CH-1:0] req,
  output logic [NUM_CH-1:0] win_oh,
  output logic              win_any
);
  always_comb begin
    win_oh = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req[i] && (win_oh == '0)) win_oh[i] = 1'b1;
    end
  end
  assign win_any = |req;
endmodule

// File: rtl/dmarq_seq.sv
module dmarq_seq #(
  parameter int CYC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic [CYC_W-1:0] blk_len,
  output logic             blk_done
);
  logic [CYC_W-1:0] cnt_q;
  logic [CYC_W-1:0] cnt_d;
  logic [CYC_W-1:0] last_cnt;
  logic             cnt_en;

  assign last_cnt = (blk_len == '0) ? '0 : blk_len - 1'b1;
  assign blk_done = active && (cnt_q == last_cnt);
  assign cnt_en   = start || active;

  always_comb begin
    if (start)         cnt_d = '0;
    else if (blk_done) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dmarq_arbiter.sv
module dmarq_arbiter #(
  parameter int NUM_CH = 3,
  parameter int BLK_W  = 8,
  parameter int CYC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_in,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [1:0]        cfg_mode,
  input  logic [BLK_W-1:0]  cfg_blocks,
  input  logic [CYC_W-1:0]  cfg_blk_cycles,
  output logic [NUM_CH-1:0] grant,
  output logic [NUM_CH-1:0] busy,
  output logic              xfer_start,
  output logic              xfer_done
);
  import dmarq_pkg::*;

  localparam logic [BLK_W-1:0] BLK_ONE = BLK_W'(1);

  logic [NUM_CH-1:0] req_s;
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] win_oh;
  logic              win_any;
  logic              blk_done;

  logic [NUM_CH-1:0] grant_q, grant_d;
  logic [NUM_CH-1:0] busy_q, busy_d;
  logic [BLK_W-1:0]  rem_q [NUM_CH];
  logic [BLK_W-1:0]  rem_d [NUM_CH];
  logic              start_q, done_q;

  logic              granted, launch;
  logic              final_blk, release_g;
  logic [NUM_CH-1:0] end_vec;
  logic [BLK_W-1:0]  cur_rem, blk_load;
  logic              cur_req;
  xfer_mode_e        mode;

  dmarq_sync #(.NUM_CH(NUM_CH)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(req_in), .sync_out(req_s)
  );

  dmarq_pend #(.NUM_CH(NUM_CH)) u_pend (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .ch_en(ch_en),
    .busy(busy_q), .clr(end_vec), .pend(pend)
  );

  dmarq_prio #(.NUM_CH(NUM_CH)) u_prio (
    .req(pend & ch_en), .win_oh(win_oh), .win_any(win_any)
  );

  dmarq_seq #(.CYC_W(CYC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(launch), .active(granted),
    .blk_len(cfg_blk_cycles), .blk_done(blk_done)
  );

  assign mode     = xfer_mode_e'(cfg_mode);
  assign granted  = |grant_q;
  assign launch   = !granted && win_any;
  assign blk_load = (cfg_blocks == '0) ? BLK_ONE : cfg_blocks;

  always_comb begin
    cur_rem = '0;
    cur_req = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (grant_q[c]) begin
        cur_rem = rem_q[c];
        cur_req = req_s[c];
      end
    end
  end

  always_comb begin
    final_blk = 1'b0;
    release_g = 1'b0;
    if (granted && blk_done) begin
      unique case (mode)
        XM_BURST: begin
          final_blk = (cur_rem <= BLK_ONE);
          release_g = final_blk;
        end
        XM_STEP: begin
          final_blk = (cur_rem <= BLK_ONE);
          release_g = 1'b1;
        end
        XM_BLOCK: begin
          final_blk = 1'b1;
          release_g = 1'b1;
        end
        XM_CONT: begin
          final_blk = (cur_rem <= BLK_ONE) || !cur_req;
          release_g = final_blk;
        end
        default: begin
          final_blk = 1'b1;
          release_g = 1'b1;
        end
      endcase
    end
    end_vec = final_blk ? grant_q : '0;
  end

  always_comb begin
    if (launch)         grant_d = win_oh;
    else if (release_g) grant_d = '0;
    else                grant_d = grant_q;
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      if (launch && win_oh[c])           busy_d[c] = 1'b1;
      else if (end_vec[c])               busy_d[c] = 1'b0;
      else if (!ch_en[c] && !grant_q[c]) busy_d[c] = 1'b0;
      else                               busy_d[c] = busy_q[c];

      if (launch && win_oh[c] && !busy_q[c])
        rem_d[c] = blk_load;
      else if (grant_q[c] && blk_done && (rem_q[c] != '0))
        rem_d[c] = rem_q[c] - 1'b1;
      else
        rem_d[c] = rem_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      busy_q  <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      grant_q <= grant_d;
      busy_q  <= busy_d;
      start_q <= launch;
      done_q  <= final_blk;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_rem
    logic rem_en;
    assign rem_en = launch || (grant_q[c] && blk_done);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rem_q[c] <= '0;
      else if (rem_en) rem_q[c] <= rem_d[c];
    end
  end

  assign grant      = grant_q;
  assign busy       = busy_q;
  assign xfer_start = start_q;
  assign xfer_done  = done_q;
endmodule

// File: rtl/dmarq_checks.sv
module dmarq_checks #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] grant,
  input logic [NUM_CH-1:0] busy,
  input logic              xfer_start,
  input logic              xfer_done,
  input logic [NUM_CH-1:0] pend,
  input logic [NUM_CH-1:0] ch_en
);
  p_onehot_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_gap_before_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && (grant != $past(grant))) |-> ($past(grant) == '0));

  p_start_on_rise_r13: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> ((grant != '0) && ($past(grant) == '0)));

  p_rise_has_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && ($past(grant) == '0)) |-> xfer_start);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (grant == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    p_busy_covers_grant_r13: assert property (@(posedge clk) disable iff (!rst_n)
      grant[c] |-> busy[c]);

    p_disable_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!ch_en[c]) |-> !pend[c]);

    p_grant_from_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant[c]) |-> $past(pend[c]));
  end
endmodule

bind dmarq_arbiter dmarq_checks #(.NUM_CH(NUM_CH)) u_checks (
  .clk(clk), .rst_n(rst_n), .grant(grant), .busy(busy),
  .xfer_start(xfer_start), .xfer_done(xfer_done),
  .pend(pend), .ch_en(ch_en)
);

// File: tb/sim_dmarq_arbiter.sv
module sim_dmarq_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] req_in;
  logic [NCH-1:0] ch_en;
  logic [1:0]     cfg_mode;
  logic [7:0]     cfg_blocks;
  logic [3:0]     cfg_blk_cycles;
  logic [NCH-1:0] grant;
  logic [NCH-1:0] busy;
  logic           xfer_start;
  logic           xfer_done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;
  int order[$];
  int starts[NCH];

  dmarq_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .ch_en(ch_en),
    .cfg_mode(cfg_mode), .cfg_blocks(cfg_blocks), .cfg_blk_cycles(cfg_blk_cycles),
    .grant(grant), .busy(busy), .xfer_start(xfer_start), .xfer_done(xfer_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference model
  int ms1[NCH], ms2[NCH], mpend[NCH], mbusy[NCH], mrem[NCH];
  int np[NCH], nb[NCH], nr[NCH];
  int mg, mcnt, mstart, mdone, ml, mw, ng;
  bit mbd, mfin, mrel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        ms1[c] = 0; ms2[c] = 0; mpend[c] = 0; mbusy[c] = 0; mrem[c] = 0;
      end
      mg = -1; mcnt = 0; mstart = 0; mdone = 0;
    end else begin
      ml  = (cfg_blk_cycles == 0) ? 1 : int'(cfg_blk_cycles);
      mbd = (mg >= 0) && (mcnt == ml - 1);
      mfin = 0; mrel = 0;
      if (mbd) begin
        case (cfg_mode)
          2'd0: begin mfin = (mrem[mg] <= 1); mrel = mfin; end
          2'd1: begin mfin = (mrem[mg] <= 1); mrel = 1; end
          2'd2: begin mfin = 1; mrel = 1; end
          default: begin mfin = (mrem[mg] <= 1) || (ms2[mg] == 0); mrel = mfin; end
        endcase
      end
      mw = -1;
      if (mg < 0)
        for (int c = 0; c < NCH; c++)
          if (mpend[c] != 0 && ch_en[c] && mw < 0) mw = c;
      for (int c = 0; c < NCH; c++) begin
        np[c] = (ch_en[c] && !(mfin && mg == c) &&
                 (mpend[c] != 0 || (ms2[c] != 0 && mbusy[c] == 0))) ? 1 : 0;
        if (mw == c)                     nb[c] = 1;
        else if (mfin && mg == c)        nb[c] = 0;
        else if (!ch_en[c] && mg != c)   nb[c] = 0;
        else                             nb[c] = mbusy[c];
        if (mw == c && mbusy[c] == 0)
          nr[c] = (cfg_blocks == 0) ? 1 : int'(cfg_blocks);
        else if (mg == c && mbd && mrem[c] > 0) nr[c] = mrem[c] - 1;
        else nr[c] = mrem[c];
      end
      if (mw >= 0)  ng = mw;
      else if (mrel) ng = -1;
      else           ng = mg;
      if (mw >= 0)       mcnt = 0;
      else if (mg >= 0)  mcnt = (mcnt == ml - 1) ? 0 : mcnt + 1;
      mstart = (mw >= 0) ? 1 : 0;
      mdone  = mfin ? 1 : 0;
      mg = ng;
      for (int c = 0; c < NCH; c++) begin
        mpend[c] = np[c]; mbusy[c] = nb[c]; mrem[c] = nr[c];
        ms2[c] = ms1[c]; ms1[c] = req_in[c] ? 1 : 0;
      end
    end
  end

  // per-cycle comparison and bookkeeping, away from the active edge
  always @(negedge clk) begin
    logic [NCH-1:0] eg, eb;
    cycles++;
    if (rst_n && !finished) begin
      eg = (mg >= 0) ? NCH'(1 << mg) : '0;
      for (int c = 0; c < NCH; c++) eb[c] = (mbusy[c] != 0);
      check(grant == eg, "R4 model grant", int'(grant), int'(eg));
      check(busy == eb, "R13 model busy", int'(busy), int'(eb));
      check(xfer_start == mstart[0], "R13 model start", int'(xfer_start), mstart);
      check(xfer_done == mdone[0], "R8 model done", int'(xfer_done), mdone);
      if (xfer_start)
        for (int c = 0; c < NCH; c++)
          if (grant[c]) begin order.push_back(c); starts[c]++; end
    end
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL R1 watchdog actual=%0d expected=<100000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_grant(input int c);
    for (int k = 0; k < 300 && !grant[c]; k++) @(negedge clk);
  endtask

  task automatic wait_fall();
    for (int k = 0; k < 300 && grant != '0; k++) @(negedge clk);
  endtask

  task automatic pulse(input int c);
    req_in[c] = 1'b1;
    tick(1);
    req_in[c] = 1'b0;
  endtask

  task automatic set_cfg(input int m, input int blks, input int len);
    cfg_mode = 2'(m); cfg_blocks = 8'(blks); cfg_blk_cycles = 4'(len);
  endtask

  initial begin
    int n, base, gap;
    rst_n = 1'b0; req_in = '0; ch_en = '1;
    set_cfg(0, 1, 1);
    for (int c = 0; c < NCH; c++) starts[c] = 0;
    tick(3);
    check(grant == '0 && busy == '0 && !xfer_start && !xfer_done, "R1 reset outputs",
          int'({grant, busy, xfer_start, xfer_done}), 0);
    rst_n = 1'b1;
    tick(1);
    check(grant == '0 && busy == '0, "R1 first cycle", int'({grant, busy}), 0);

    // R2, R3, R8: single-cycle pulse, latency and burst length
    set_cfg(0, 2, 3);
    req_in[1] = 1'b1; tick(1); n = 1; req_in[1] = 1'b0;
    while (!grant[1] && n < 20) begin tick(1); n++; end
    check(n == 4, "R2 start latency", n, 4);
    n = 0;
    while (grant[1] && n < 50) begin tick(1); n++; end
    check(n == 6, "R8 burst grant length", n, 6);
    check(xfer_done == 1'b1, "R8 done after burst", int'(xfer_done), 1);
    tick(10);
    check(starts[1] == 1, "R3 pulse served once", starts[1], 1);

    // R5: re-request inside busy window ignored
    set_cfg(0, 4, 2);
    base = starts[0];
    pulse(0); wait_grant(0); tick(2); pulse(0);
    wait_fall(); tick(10);
    check(starts[0] - base == 1, "R5 re-request ignored", starts[0] - base, 1);

    // R4: fixed priority among simultaneous requests
    set_cfg(2, 1, 2);
    order.delete();
    req_in = 3'b111; tick(1); req_in = '0;
    tick(30);
    check(order.size() == 3, "R4 three grants", order.size(), 3);
    if (order.size() == 3) begin
      check(order[0] == 0, "R4 first ch0", order[0], 0);
      check(order[1] == 1, "R4 second ch1", order[1], 1);
      check(order[2] == 2, "R4 third ch2", order[2], 2);
    end

    // R6: higher-priority pending channel takes over after one idle cycle
    set_cfg(2, 1, 4);
    order.delete();
    pulse(1); wait_grant(1);
    req_in[1] = 1'b1; tick(1); pulse(0);
    wait_fall();
    gap = 0;
    while (grant == '0 && gap < 20) begin tick(1); gap++; end
    check(gap == 1, "R6 one-cycle gap", gap, 1);
    check(grant[0] == 1'b1, "R6 preempt by ch0", int'(grant), 1);
    req_in[1] = 1'b0;
    tick(30);
    check(order.size() == 3, "R6 grant count", order.size(), 3);
    if (order.size() == 3)
      check(order[0] == 1 && order[1] == 0 && order[2] == 1, "R6 order 1,0,1",
            order[0] * 100 + order[1] * 10 + order[2], 101);

    // R7: same channel re-served after two-cycle gap
    set_cfg(2, 1, 3);
    req_in[2] = 1'b1;
    wait_grant(2); wait_fall();
    gap = 0;
    while (grant == '0 && gap < 20) begin tick(1); gap++; end
    check(gap == 2, "R7 same-channel gap", gap, 2);
    check(grant[2] == 1'b1, "R7 same channel again", int'(grant), 4);
    req_in[2] = 1'b0;
    tick(20);

    // R9: step mode interleaves with another channel
    set_cfg(1, 3, 4);
    order.delete();
    pulse(2); wait_grant(2); pulse(1);
    tick(60);
    check(order.size() == 6, "R9 step grant count", order.size(), 6);
    if (order.size() == 6)
      check(order[0] == 2 && order[1] == 1 && order[2] == 1 && order[3] == 1 &&
            order[4] == 2 && order[5] == 2, "R9 step order 2,1,1,1,2,2",
            order[0] * 10 + order[1], 21);

    // R10: block mode ignores block count
    set_cfg(2, 5, 3);
    base = starts[0];
    pulse(0); wait_grant(0);
    n = 0;
    while (grant[0] && n < 50) begin tick(1); n++; end
    check(n == 3, "R10 one block length", n, 3);
    tick(10);
    check(starts[0] - base == 1, "R10 single grant", starts[0] - base, 1);

    // R11: continuous stops when request drops, and at count exhaustion
    set_cfg(3, 10, 2);
    req_in[0] = 1'b1; wait_grant(0);
    tick(5); req_in[0] = 1'b0;
    n = 5;
    while (grant[0] && n < 50) begin tick(1); n++; end
    check(n == 8, "R11 stop on request drop", n, 8);
    set_cfg(3, 2, 2);
    req_in[2] = 1'b1; wait_grant(2);
    n = 0;
    while (grant[2] && n < 50) begin tick(1); n++; end
    check(n == 4, "R11 stop on count", n, 4);
    req_in[2] = 1'b0;
    tick(20);

    // R12: disabled channel captures nothing; disabling drops pending
    set_cfg(2, 1, 8);
    base = starts[1];
    ch_en[1] = 1'b0; pulse(1); tick(10);
    check(starts[1] == base, "R12 disabled no capture", starts[1] - base, 0);
    ch_en[1] = 1'b1;
    pulse(0); wait_grant(0); pulse(1); tick(4);
    ch_en[1] = 1'b0; tick(1); ch_en[1] = 1'b1;
    wait_fall(); tick(15);
    check(starts[1] == base, "R12 pending cleared", starts[1] - base, 0);

    // zero-valued config fields count as one
    set_cfg(0, 0, 0);
    pulse(2); wait_grant(2);
    n = 0;
    while (grant[2] && n < 50) begin tick(1); n++; end
    check(n == 1, "R8 zero config length", n, 1);
    tick(5);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule